// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column address for every beat of a synchronous DRAM burst. A controller pulses a start strobe together with the starting column, a length code and an ordering bit. From the next cycle on, the block presents one column per clock with a valid flag. It marks the final beat so that the controller can time an automatic precharge or issue its next command.

Two orderings are available. Sequential ordering wraps inside an aligned block of the burst length. Interleaved ordering XORs the starting column with the beat number. A full-page length steps through the whole row without end until a stop request arrives. A stop input cuts any burst short. A fresh start strobe abandons whatever burst is running and begins the new one.

Top module: `burst_col_seq`

## Requirements
- R1: While reset is held, and in the first cycle after it, `valid_o` and `last_o` are 0 and `col_o` is 0.
- R2: In the cycle after a cycle with `start_i` high, `valid_o` is 1 and `col_o` equals the `start_col_i` sampled with the strobe. Each further cycle of the burst shows the next beat.
- R3: With `type_i` = 0 and length code 000, 001, 010 or 011, the burst has 1, 2, 4 or 8 beats. The low log2(N) bits count up from the start value and wrap, and the upper bits keep their start value.
- R4: With `type_i` = 1 and length code 000 to 011, the column on beat k is the start column XOR k, with k below N.
- R5: Length code 111 selects full page. The column rises by one per cycle modulo 2^COL_W, `type_i` has no effect, and `last_o` is never asserted.
- R6: `last_o` is high only on beat N-1 of a 1, 2, 4 or 8 beat burst. `valid_o` is low in the following cycle unless a start strobe arrived.
- R7: `stop_i` high during a valid beat ends the burst, so that `valid_o` is 0 in the next cycle. `stop_i` while idle has no effect.
- R8: `start_i` during an active burst restarts from the new column in the next cycle. This includes a start on the last beat and a start together with `stop_i`. Start takes precedence over stop.
- R9: The unused length codes 100, 101 and 110 behave as a burst of length 1.
- R10: `col_o` is 0 in every cycle where `valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a burst with the fields below |
| start_col_i | input | COL_W | Starting column |
| len_code_i | input | 3 | Burst length code |
| type_i | input | 1 | 0 = sequential, 1 = interleaved |
| stop_i | input | 1 | End the running burst |
| col_o | output | COL_W | Current column |
| valid_o | output | 1 | A beat is presented |
| last_o | output | 1 | The presented beat is the final one |

## Verification
Three events can fall in the same cycle. A stop can arrive on the final beat, where stop and natural end agree. A new start can arrive on the final beat. A start can arrive together with a stop, and then the start must win. The bench provokes each one by placing the stop or the start on every beat index of short bursts. It judges the outcome with a behavioural model that applies start first, then stop or end-of-burst. That model is compared with the column, valid and last outputs on every clock.

// File: rtl/burst_col_seq.sv
module burst_col_seq #(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [2:0]       len_code_i,
  input  logic             type_i,
  input  logic             stop_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o
);

  localparam logic [2:0] CODE_FULL = 3'b111;

  logic             active_q;
  logic [COL_W-1:0] beat_q, base_q, mask;
  logic [2:0]       code_q;
  logic             type_q;

  wire full = (code_q == CODE_FULL);

  always_comb begin
    case (code_q)
      3'b001:    mask = COL_W'(1);
      3'b010:    mask = COL_W'(3);
      3'b011:    mask = COL_W'(7);
      CODE_FULL: mask = '1;
      default:   mask = '0;
    endcase
  end

  wire [COL_W-1:0] seq_col = (base_q & ~mask) | ((base_q + beat_q) & mask);
  wire [COL_W-1:0] ilv_col = base_q ^ (beat_q & mask);

  assign valid_o = active_q;
  assign last_o  = active_q && !full && (beat_q == mask);
  assign col_o   = !active_q ? '0 : (type_q && !full) ? ilv_col : seq_col;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      beat_q   <= '0;
      base_q   <= '0;
      code_q   <= '0;
      type_q   <= 1'b0;
    end else if (start_i) begin
      active_q <= 1'b1;
      beat_q   <= '0;
      base_q   <= start_col_i;
      code_q   <= len_code_i;
      type_q   <= type_i;
    end else if (active_q) begin
      if (stop_i || last_o) active_q <= 1'b0;
      else                  beat_q   <= beat_q + COL_W'(1);
    end
  end

  a_r2_start_loads: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (valid_o && col_o == $past(start_col_i)));

  a_r5_full_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && full && !stop_i && !start_i) |=> (valid_o && col_o == $past(col_o) + COL_W'(1)));

  a_r5_full_no_last: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && full) |-> !last_o);

  a_r6_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (last_o && !start_i) |=> !valid_o);

  a_r6_last_valid: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> valid_o);

  a_r7_stop_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && stop_i && !start_i) |=> !valid_o);

  a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> (col_o == '0));

endmodule

// File: tb/tb_burst_col_seq.sv
`timescale 1ns/1ps
module tb_burst_col_seq;
  localparam int COL_W = 9;
  localparam int NCOL  = 1 << COL_W;

  logic clk = 0, rst_n = 0, start_i = 0, type_i = 0, stop_i = 0;
  logic [COL_W-1:0] start_col_i = '0;
  logic [2:0] len_code_i = '0;
  logic [COL_W-1:0] col_o;
  logic valid_o, last_o;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  int m_act = 0, m_beat = 0, m_base = 0, m_len = 0, m_typ = 0;

  burst_col_seq #(.COL_W(COL_W)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
    .len_code_i(len_code_i), .type_i(type_i), .stop_i(stop_i),
    .col_o(col_o), .valid_o(valid_o), .last_o(last_o));

  always #2.5 clk = ~clk;

  function automatic int blen(int code);
    if (code == 7) return 0;
    if (code <= 3) return 1 << code;
    return 1;
  endfunction

  function automatic int exp_col();
    int n;
    if (!m_act) return 0;
    n = blen(m_len);
    if (n == 0) return (m_base + m_beat) % NCOL;
    if (m_typ) return m_base ^ m_beat;
    return (m_base / n) * n + ((m_base % n) + m_beat) % n;
  endfunction

  function automatic int exp_last();
    int n = blen(m_len);
    return (m_act && n != 0 && m_beat == n - 1) ? 1 : 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) m_act = 0;
    else if (start_i) begin
      m_act = 1; m_beat = 0; m_base = start_col_i; m_len = len_code_i; m_typ = type_i;
    end else if (m_act) begin
      if (stop_i || exp_last()) m_act = 0;
      else m_beat = (m_beat + 1) % NCOL;
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (rst_n && !done) begin
      string tag;
      if (!m_act) tag = "R10";
      else if (m_len >= 4 && m_len <= 6) tag = "R9";
      else if (m_len == 7) tag = "R5";
      else if (m_typ) tag = "R4";
      else tag = "R3";
      checks += 3;
      if (int'(col_o) != exp_col()) begin
        errors++;
        $display("FAIL %s col actual %0d expected %0d", tag, col_o, exp_col());
      end
      if (int'(valid_o) != m_act) begin
        errors++;
        $display("FAIL R7 valid actual %0d expected %0d", valid_o, m_act);
      end
      if (int'(last_o) != exp_last()) begin
        errors++;
        $display("FAIL R6 last actual %0d expected %0d", last_o, exp_last());
      end
    end
    if (cyc == 150000 && !done) begin
      errors++;
      $display("FAIL R2 watchdog actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  // R2: start strobe then per-beat stop at beat index stop_at (-1 = none)
  task automatic burst(int col, int code, int typ, int stop_at, int ncyc);
    start_i = 1; start_col_i = COL_W'(col); len_code_i = 3'(code); type_i = typ[0];
    tick();
    start_i = 0;
    for (int i = 0; i < ncyc; i++) begin
      stop_i = (i == stop_at);
      tick();
    end
    stop_i = 0;
    tick(2);
  endtask

  initial begin
    tick(3);
    // R1: reset values
    checks++;
    if (valid_o !== 1'b0 || last_o !== 1'b0 || col_o !== '0) begin
      errors++;
      $display("FAIL R1 reset actual %0d/%0d/%0d expected 0/0/0", valid_o, last_o, col_o);
    end
    rst_n = 1;
    tick();
    checks++;
    if (valid_o !== 1'b0 || col_o !== '0) begin
      errors++;
      $display("FAIL R1 after reset actual %0d/%0d expected 0/0", valid_o, col_o);
    end
    // R7: stop while idle has no effect
    stop_i = 1; tick(3); stop_i = 0;
    // R3 R4 R9: all codes, both orderings, all low offsets plus high columns
    for (int t = 0; t < 2; t++)
      for (int c = 0; c < 7; c++)
        for (int o = 0; o < 20; o++)
          burst((o < 16) ? o : (o * 97) % NCOL, c, t, -1, 10);
    // R7: stop on every beat of each short length
    for (int t = 0; t < 2; t++)
      for (int c = 1; c < 4; c++)
        for (int s = 0; s < (1 << c); s++)
          for (int o = 0; o < 8; o++)
            burst(o + 40, c, t, s, 10);
    // R5: full page wraps past the row end, then stop
    burst(500, 7, 0, 530, 534);
    burst(3, 7, 1, 20, 24);
    // R8: restart mid-burst, on last beat, and with stop in the same cycle
    for (int t = 0; t < 2; t++)
      for (int r = 0; r < 8; r++) begin
        start_i = 1; start_col_i = 9'd17; len_code_i = 3'b011; type_i = t[0]; tick();
        start_i = 0; tick(r);
        start_i = 1; stop_i = r[0]; start_col_i = COL_W'(100 + r); len_code_i = 3'b010; tick();
        start_i = 0; stop_i = 0; tick(8);
      end
    // R8: restart into full page and out of it
    start_i = 1; start_col_i = 9'd510; len_code_i = 3'b111; tick();
    start_i = 0; tick(6);
    start_i = 1; stop_i = 1; start_col_i = 9'd5; len_code_i = 3'b001; tick();
    start_i = 0; stop_i = 0; tick(5);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule